// File: doc/BRIEF.md
# Multicycle Instruction Fetch Sequencer

This block is the control state machine that walks a 16-bit, single-bus processor datapath through one instruction fetch. It does not touch data. Each cycle it drives a fixed set of control strobes that move the program counter into the memory address register. Those strobes then read memory into the memory data register, copy that word over the shared bus into the instruction register, and step the program counter. The fetch takes five transfer steps. A one-cycle hand-off state follows them, in which the block raises `done` for the decode logic.

A fetch begins when `start` is seen in the idle state. `start` is a plain level request and has no valid/ready handshake. The block holds no data path, so it applies no back-pressure. A request stays armed until it launches a fetch. A new fetch needs `start` to be low for at least one cycle after the previous launch. Holding `start` high therefore gives exactly one fetch.

Top module: `fetch_seq`

## Requirements
- R1: `rst` is a synchronous active-high reset. In the cycle after a reset edge, `state_o` is 0 (idle), `done` is 0, and every strobe output is 0, with `pc_sel` at 2'b00.
- R2: When the block is idle and `start` is high with the request armed, `state_o` becomes 1 one cycle later. The request is armed after reset. It is also armed once `start` has been sampled low after the last launch.
- R3: After launch, `state_o` runs through 1, 2, 3, 4, 5 and 6, one cycle each, and then returns to 0. `start` does not alter this run.
- R4: In state 1, `pc_gate` and `mar_ld` are 1 and every other strobe is 0.
- R5: In state 2, `mem_en` and `mem_rw` are 1, where `mem_rw`=1 means read, and every other strobe is 0.
- R6: In state 3, only `mdr_ld` is 1.
- R7: In state 4, `mdr_gate`, `ir_ld` and `pc_ld` are 1 and `pc_sel` is 2'b00, which selects the incremented PC. Every other strobe is 0.
- R8: In states 0, 5 and 6, all strobes are 0 and `pc_sel` is 2'b00.
- R9: `done` is 1 only in state 6, and therefore for exactly one cycle per fetch.
- R10: `pc_gate` and `mdr_gate` are never both 1 in the same cycle.
- R11: If `start` stays high, the block stays idle after a fetch. It starts no second fetch until `start` has been low for at least one cycle.
- R12: With a datapath attached, the instruction register holds mem[old PC] after a fetch, and the PC holds old PC + 1 modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Fetch request level |
| pc_gate | output | 1 | Drive the PC onto the shared bus |
| mar_ld | output | 1 | Load the MAR from the bus |
| mem_rw | output | 1 | Memory direction, 1 = read |
| mem_en | output | 1 | Memory access enable |
| mdr_ld | output | 1 | Load the MDR from memory |
| mdr_gate | output | 1 | Drive the MDR onto the shared bus |
| ir_ld | output | 1 | Load the IR from the bus |
| pc_sel | output | 2 | PC source select, 2'b00 = PC + 1 |
| pc_ld | output | 1 | Load the PC |
| done | output | 1 | One-cycle fetch-complete pulse |
| state_o | output | 3 | Current step code, 0 idle, 1 to 5 fetch steps, 6 hand-off |

## Verification
All strobes decode directly from the state register. A wrong or skipped state therefore shows up at the ports in the same cycle: `state_o` is off, and the strobe set does not match the per-step table. The attached datapath model reports the error one cycle later, at the hand-off, as a wrong IR word or a wrong PC value. A fault in the request-arming flag appears as an extra fetch or a missing fetch. This shows in `state_o` within one cycle of the machine returning to idle. The bench sweeps hundreds of consecutive PC values across the 16-bit wrap.

// File: rtl/fetch_pkg.sv
package fetch_pkg;
  localparam int STATE_W = 3;
  localparam int PCSEL_W = 2;
  localparam logic [PCSEL_W-1:0] PCSEL_INC = '0;

  typedef enum logic [STATE_W-1:0] {
    ST_IDLE = 3'd0,
    ST_F1   = 3'd1,
    ST_F2   = 3'd2,
    ST_F3   = 3'd3,
    ST_F4   = 3'd4,
    ST_F5   = 3'd5,
    ST_DEC  = 3'd6
  } fstate_t;

  typedef struct packed {
    logic               pc_gate;
    logic               mar_ld;
    logic               mem_rw;
    logic               mem_en;
    logic               mdr_ld;
    logic               mdr_gate;
    logic               ir_ld;
    logic [PCSEL_W-1:0] pc_sel;
    logic               pc_ld;
  } strobe_t;
endpackage

// File: rtl/fetch_req_arm.sv
module fetch_req_arm (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic launch,
  output logic armed
);
  // A request is consumed at launch and re-armed once start is seen low.
  always_ff @(posedge clk) begin
    if (rst)         armed <= 1'b1;
    else if (launch) armed <= 1'b0;
    else if (!start) armed <= 1'b1;
  end
endmodule

// File: rtl/fetch_step_fsm.sv
module fetch_step_fsm
  import fetch_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    go,
  output fstate_t st
);
  fstate_t st_nx;

  always_comb begin
    st_nx = st;
    unique case (st)
      ST_IDLE: st_nx = go ? ST_F1 : ST_IDLE;
      ST_F1:   st_nx = ST_F2;
      ST_F2:   st_nx = ST_F3;
      ST_F3:   st_nx = ST_F4;
      ST_F4:   st_nx = ST_F5;
      ST_F5:   st_nx = ST_DEC;
      ST_DEC:  st_nx = ST_IDLE;
      default: st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st <= ST_IDLE;
    else     st <= st_nx;
  end
endmodule

// File: rtl/fetch_strobe_dec.sv
module fetch_strobe_dec
  import fetch_pkg::*;
(
  input  fstate_t st,
  output strobe_t stb,
  output logic    hand_off
);
  // Moore decode: every strobe is a pure function of the current step.
  always_comb begin
    stb        = '0;
    stb.pc_sel = PCSEL_INC;
    hand_off   = 1'b0;
    unique case (st)
      ST_F1: begin
        stb.pc_gate = 1'b1;
        stb.mar_ld  = 1'b1;
      end
      ST_F2: begin
        stb.mem_rw = 1'b1;
        stb.mem_en = 1'b1;
      end
      ST_F3: stb.mdr_ld = 1'b1;
      ST_F4: begin
        stb.mdr_gate = 1'b1;
        stb.ir_ld    = 1'b1;
        stb.pc_ld    = 1'b1;
      end
      ST_DEC:  hand_off = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/fetch_seq.sv
module fetch_seq
  import fetch_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  output logic               pc_gate,
  output logic               mar_ld,
  output logic               mem_rw,
  output logic               mem_en,
  output logic               mdr_ld,
  output logic               mdr_gate,
  output logic               ir_ld,
  output logic [PCSEL_W-1:0] pc_sel,
  output logic               pc_ld,
  output logic               done,
  output logic [STATE_W-1:0] state_o
);
  fstate_t st;
  strobe_t stb;
  logic    armed;
  logic    go;

  assign go = (st == ST_IDLE) && start && armed;

  fetch_req_arm u_arm (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .launch (go),
    .armed  (armed)
  );

  fetch_step_fsm u_fsm (
    .clk (clk),
    .rst (rst),
    .go  (go),
    .st  (st)
  );

  fetch_strobe_dec u_dec (
    .st       (st),
    .stb      (stb),
    .hand_off (done)
  );

  assign pc_gate  = stb.pc_gate;
  assign mar_ld   = stb.mar_ld;
  assign mem_rw   = stb.mem_rw;
  assign mem_en   = stb.mem_en;
  assign mdr_ld   = stb.mdr_ld;
  assign mdr_gate = stb.mdr_gate;
  assign ir_ld    = stb.ir_ld;
  assign pc_sel   = stb.pc_sel;
  assign pc_ld    = stb.pc_ld;
  assign state_o  = st;
endmodule

// File: rtl/fetch_seq_chk.sv
module fetch_seq_chk
  import fetch_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic               start,
  input logic               pc_gate,
  input logic               mar_ld,
  input logic               mem_rw,
  input logic               mem_en,
  input logic               mdr_ld,
  input logic               mdr_gate,
  input logic               ir_ld,
  input logic [PCSEL_W-1:0] pc_sel,
  input logic               pc_ld,
  input logic               done,
  input logic [STATE_W-1:0] state_o
);
  logic rst_q = 1'b0;
  always_ff @(posedge clk) rst_q <= rst;

  // R1: the cycle after a reset edge is idle and quiet
  always_ff @(posedge clk) begin
    if (rst_q && !rst) begin
      a_r1_reset_idle: assert (state_o == '0 && !done && !pc_gate && !mar_ld &&
        !mem_en && !mem_rw && !mdr_ld && !mdr_gate && !ir_ld && !pc_ld &&
        pc_sel == PCSEL_INC);
    end
  end

  // R10
  a_r10_one_driver: assert property (@(posedge clk) disable iff (rst)
    !(pc_gate && mdr_gate));

  // R3
  a_r3_step_advance: assert property (@(posedge clk) disable iff (rst)
    (state_o >= 3'd1 && state_o <= 3'd5) |=> (state_o == $past(state_o) + 3'd1));

  a_r3_handoff_exit: assert property (@(posedge clk) disable iff (rst)
    (state_o == 3'd6) |=> (state_o == 3'd0));

  // R5: address capture is followed by a read access
  a_r5_read_follows: assert property (@(posedge clk) disable iff (rst)
    mar_ld |=> (mem_en && mem_rw));

  // R6: the read access is followed by the MDR capture
  a_r6_mdr_follows: assert property (@(posedge clk) disable iff (rst)
    mem_en |=> mdr_ld);

  // R7: the MDR capture is followed by the IR and PC update
  a_r7_ir_follows: assert property (@(posedge clk) disable iff (rst)
    mdr_ld |=> (ir_ld && pc_ld && mdr_gate && pc_sel == PCSEL_INC));

  // R8: loads are released after the IR step
  a_r8_release: assert property (@(posedge clk) disable iff (rst)
    ir_ld |=> (!ir_ld && !pc_ld && !mdr_gate));

  // R9
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r9_done_after_f5: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> ($past(state_o) == 3'd5));

  // R2
  a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (state_o == 3'd0 && !start) |=> (state_o == 3'd0));
endmodule

bind fetch_seq fetch_seq_chk i_chk (
  .clk      (clk),
  .rst      (rst),
  .start    (start),
  .pc_gate  (pc_gate),
  .mar_ld   (mar_ld),
  .mem_rw   (mem_rw),
  .mem_en   (mem_en),
  .mdr_ld   (mdr_ld),
  .mdr_gate (mdr_gate),
  .ir_ld    (ir_ld),
  .pc_sel   (pc_sel),
  .pc_ld    (pc_ld),
  .done     (done),
  .state_o  (state_o)
);

// File: tb/test_fetch_seq.sv
`timescale 1ns/1ps
module test_fetch_seq;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic pc_gate, mar_ld, mem_rw, mem_en, mdr_ld, mdr_gate, ir_ld, pc_ld, done;
  logic [1:0] pc_sel;
  logic [2:0] state_o;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  fetch_seq i_fetch_seq (
    .clk(clk), .rst(rst), .start(start),
    .pc_gate(pc_gate), .mar_ld(mar_ld), .mem_rw(mem_rw), .mem_en(mem_en),
    .mdr_ld(mdr_ld), .mdr_gate(mdr_gate), .ir_ld(ir_ld), .pc_sel(pc_sel),
    .pc_ld(pc_ld), .done(done), .state_o(state_o)
  );

  // Datapath model: shared bus, PC, MAR, memory, MDR, IR
  logic [15:0] mem [256];
  logic [15:0] pc, mar, rdat, mdr, ir, bus;
  logic        ld_pc = 1'b0;
  logic [15:0] ld_val = '0;

  assign bus = pc_gate ? pc : (mdr_gate ? mdr : 16'h0000);

  always_ff @(posedge clk) begin
    if (ld_pc) pc <= ld_val;
    else if (pc_ld && pc_sel == 2'b00) pc <= pc + 16'd1;
    if (mar_ld) mar <= bus;
    if (mem_en && mem_rw) rdat <= mem[mar[7:0]];
    if (mdr_ld) mdr <= rdat;
    if (ir_ld) ir <= bus;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Expected strobe vector {pc_gate,mar_ld,mem_rw,mem_en,mdr_ld,mdr_gate,ir_ld,pc_ld,pc_sel}
  function automatic logic [9:0] exp_stb(input int s);
    case (s)
      1: return 10'b11_0000_00_00;
      2: return 10'b00_1100_00_00;
      3: return 10'b00_0010_00_00;
      4: return 10'b00_0001_11_00;
      default: return 10'b0;
    endcase
  endfunction

  function automatic string step_req(input int s);
    case (s)
      1: return "R4";
      2: return "R5";
      3: return "R6";
      4: return "R7";
      default: return "R8";
    endcase
  endfunction

  logic [9:0] stb_now;
  assign stb_now = {pc_gate, mar_ld, mem_rw, mem_en, mdr_ld, mdr_gate, ir_ld, pc_ld, pc_sel};

  // R10: bus contention check every cycle
  always @(negedge clk) begin
    if (!rst) chk(!(pc_gate && mdr_gate), "R10", {pc_gate, mdr_gate}, 0);
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // One fetch; start raised at a negedge, optionally left high afterwards
  task automatic do_fetch(input bit hold);
    logic [15:0] old_pc;
    old_pc = pc;
    start = 1'b1;
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      chk(state_o == 3'(k), "R3", state_o, k);
      chk(stb_now == exp_stb(k), step_req(k), stb_now, exp_stb(k));
      chk(done == (k == 6), "R9", done, k == 6);
      if (k == 1 && !hold) start = 1'b0;
      if (k == 6) begin
        chk(ir == mem[old_pc[7:0]], "R12", ir, mem[old_pc[7:0]]);
        chk(pc == old_pc + 16'd1, "R12", pc, old_pc + 16'd1);
      end
    end
    @(negedge clk);
    chk(state_o == 3'd0 && !done, "R3", state_o, 0);
    chk(stb_now == 10'b0, "R8", stb_now, 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 16'(i * 40503) ^ 16'h5A3C;
    ld_pc = 1'b1;
    ld_val = 16'hFF80;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    ld_pc = 1'b0;
    // R1: quiet after reset
    chk(state_o == 3'd0 && !done && stb_now == 10'b0, "R1", {state_o, stb_now}, 0);
    // R2: idle with start low stays idle
    repeat (3) begin
      @(negedge clk);
      chk(state_o == 3'd0, "R2", state_o, 0);
    end
    // R12 sweep across the 16-bit PC wrap
    for (int n = 0; n < 300; n++) do_fetch(1'b0);

    // R11: start held high gives exactly one fetch
    do_fetch(1'b1);
    repeat (5) begin
      @(negedge clk);
      chk(state_o == 3'd0, "R11", state_o, 0);
    end
    start = 1'b0;
    @(negedge clk);
    chk(state_o == 3'd0, "R11", state_o, 0);
    do_fetch(1'b0);

    // R1: reset in mid-fetch
    start = 1'b1;
    repeat (3) @(negedge clk);
    chk(state_o == 3'd3, "R3", state_o, 3);
    start = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(state_o == 3'd0 && !done && stb_now == 10'b0, "R1", {state_o, stb_now}, 0);
    // R2: armed after reset, fetch resumes
    do_fetch(1'b0);
    // R2: a fetch can begin immediately after the hand-off
    do_fetch(1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule